// File: doc/BRIEF.md
# MSI Snooping Cache Line Controller

This block is the coherence engine of one write-back cache in a small bus-based multiprocessor. It keeps a direct-mapped store of lines, each with a tag, one data word and a three-state coherence tag: Invalid, Shared or Modified. It serves processor reads and writes. When an access cannot be finished locally, it asks an external arbiter for the shared bus and, once granted, drives a one-cycle bus transaction. The transaction can be a read, a read-for-ownership, an invalidating upgrade or a victim write-back.

At the same time the block watches every transaction that other caches place on the bus. A foreign transaction that touches a line held here changes that line's state. If the line is held Modified and the foreign transaction fetches it, this cache drives the data in place of memory in that same cycle. A foreign upgrade or read-for-ownership removes the local copy. The processor side stalls, with its ready output low, until the line is present in a state that allows the access.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, so no bus request, bus command or processor ready is seen while the processor is idle, and the first access to any address misses.
- R2: A read to a line held Shared or Modified completes in the cycle it is presented (ready high, data valid) with no bus request.
- R3: A read miss requests the bus, drives a read (command code 1) in the granted cycle, installs the line Shared, and completes one cycle after the grant.
- R4: A write to a line held Modified completes in the cycle it is presented, with no bus transaction.
- R5: A write to a line held Shared drives an upgrade (command code 3) in the granted cycle, moves the line to Modified without refetching, and completes one cycle after the grant.
- R6: A write miss drives a read-for-ownership (command code 2), installs the line directly in Modified, and completes one cycle after the grant.
- R7: A miss whose slot holds a different line in Modified first drives a write-back (command code 4) carrying the victim's address and data, then fetches the new line in a second granted transaction.
- R8: The bus request stays high until a grant arrives. A command other than idle (code 0) is driven only in a cycle where request and grant are both high.
- R9: When a foreign read (code 1) targets a line held Modified, the block raises its flush output with the line's data in that same cycle, and the local copy becomes Shared.
- R10: A foreign read-for-ownership or upgrade (codes 2 and 3) that targets a line held here makes the line Invalid, and a Modified line is flushed as part of that response.
- R11: When a local hit and a foreign transaction on the same line fall in one cycle, the local access is ordered first. A local write hit's data is what the flush carries.
- R12: When two caches holding a line Shared both write it, the cache granted first wins with an upgrade. The other cache's copy becomes Invalid, so it refetches with a read-for-ownership. The two caches never both hold the line Modified.
- R13: Every read and every bus fill returns the value of the most recently completed write to that address, and every write-back carries that value too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuReq | input | 1 | Processor access request, held until cpuReady |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Word address of the access |
| cpuWdata | input | DATA_W | Write data |
| cpuReady | output | 1 | Access completes in this cycle |
| cpuRdata | output | DATA_W | Read data, valid with cpuReady on a read |
| busReq | output | 1 | Request for the shared bus |
| busGnt | input | 1 | Grant from the external arbiter |
| busCmdOut | output | 3 | Command driven by this cache (0 idle, 1 read, 2 read-for-ownership, 3 upgrade, 4 write-back) |
| busAddrOut | output | ADDR_W | Address of the driven command |
| busDataOut | output | DATA_W | Data of a driven write-back |
| busCmdIn | input | 3 | Command currently on the bus |
| busAddrIn | input | ADDR_W | Address currently on the bus |
| busDataIn | input | DATA_W | Fill data on the bus (from memory or a flushing cache) |
| snoopFlush | output | 1 | This cache supplies data for the bus transaction |
| snoopData | output | DATA_W | Data supplied with snoopFlush |

## Verification
The two functions that share a cycle are a local hit and the snoop response to a foreign transaction on the same line. The bench provokes this with a write race: two processors holding one line Shared write it in the same cycle. The winner's write hit then lands in the very cycle in which the loser's read-for-ownership is snooped. The bench judges it from the latencies (one and two cycles), the command order (upgrade, then read-for-ownership from the other cache), and the single flush carrying the winner's data. It also checks that later reads from both processors return the loser's value.

// File: rtl/msi_pkg.sv
package msi_pkg;

  typedef enum logic [1:0] {
    LINE_I = 2'd0,
    LINE_S = 2'd1,
    LINE_M = 2'd2
  } lineState_e;

  typedef enum logic [2:0] {
    BUS_IDLE = 3'd0,
    BUS_RD   = 3'd1,
    BUS_RDX  = 3'd2,
    BUS_UPG  = 3'd3,
    BUS_WB   = 3'd4
  } busCmd_e;

  // Strobes from the control to the line store, all applied at the next edge.
  typedef struct packed {
    logic       fillEn;    // install line at cpu index from bus data
    logic       fillMod;   // installed state: 1 = Modified, 0 = Shared
    logic       upgEn;     // cpu-index line Shared -> Modified
    logic       wbEn;      // cpu-index victim -> Invalid
    logic       wrEn;      // write hit data into cpu-index line
    logic       snoopEn;   // apply snoopNext at snoop index
    lineState_e snoopNext;
  } lineStrobe_t;

endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  lineStrobe_t       st,
  input  logic [IDX_W-1:0]  cpuIdx,
  input  logic [TAG_W-1:0]  cpuTag,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] fillData,
  input  logic [IDX_W-1:0]  snpIdx,
  input  logic [TAG_W-1:0]  snpTag,
  output lineState_e        cpuState,
  output logic              cpuTagHit,
  output logic [DATA_W-1:0] cpuData,
  output logic [TAG_W-1:0]  victimTag,
  output lineState_e        snpState,
  output logic              snpTagHit,
  output logic [DATA_W-1:0] snpData
);
  localparam int LINES = 1 << IDX_W;

  lineState_e        lineState [LINES];
  logic [TAG_W-1:0]  lineTag   [LINES];
  logic [DATA_W-1:0] lineData  [LINES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) lineState[i] <= LINE_I;
    end else begin
      if (st.fillEn) lineState[cpuIdx] <= st.fillMod ? LINE_M : LINE_S;
      if (st.upgEn)  lineState[cpuIdx] <= LINE_M;
      if (st.wbEn)   lineState[cpuIdx] <= LINE_I;
      if (st.snoopEn) lineState[snpIdx] <= st.snoopNext;
    end
  end

  always_ff @(posedge clk) begin
    if (st.fillEn) begin
      lineTag[cpuIdx]  <= cpuTag;
      lineData[cpuIdx] <= fillData;
    end
    if (st.wrEn) lineData[cpuIdx] <= cpuWdata;
  end

  assign cpuState  = lineState[cpuIdx];
  assign cpuTagHit = (lineTag[cpuIdx] == cpuTag);
  assign cpuData   = lineData[cpuIdx];
  assign victimTag = lineTag[cpuIdx];
  assign snpState  = lineState[snpIdx];
  assign snpTagHit = (lineTag[snpIdx] == snpTag);
  assign snpData   = lineData[snpIdx];

  // R9
  m_demoted_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.snoopEn && snpState == LINE_M) |=> (lineState[$past(snpIdx)] != LINE_M));

  // R5
  upg_from_shared_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.upgEn |-> (cpuTagHit && cpuState == LINE_S));

endmodule

// File: rtl/msi_snoop_ctl.sv
module msi_snoop_ctl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuReady,
  output logic              busReq,
  input  logic              busGnt,
  output logic [2:0]        busCmdOut,
  output logic [ADDR_W-1:0] busAddrOut,
  input  logic [2:0]        busCmdIn,
  input  logic [ADDR_W-1:0] busAddrIn,
  output logic              snoopFlush,
  output logic [DATA_W-1:0] snoopData,
  input  lineState_e        cpuState,
  input  logic              cpuTagHit,
  input  logic [DATA_W-1:0] cpuData,
  input  logic [ADDR_W-IDX_W-1:0] victimTag,
  input  lineState_e        snpState,
  input  logic              snpTagHit,
  input  logic [DATA_W-1:0] snpData,
  output lineStrobe_t       st
);
  logic    hitS, hitM, hitOk, granted, dirtyVictim, snActive, sameIdx;
  busCmd_e cmd, inCmd;

  always_comb begin
    inCmd       = busCmd_e'(busCmdIn);
    hitM        = cpuTagHit && (cpuState == LINE_M);
    hitS        = cpuTagHit && (cpuState == LINE_S);
    hitOk       = cpuReq && (hitM || (hitS && !cpuWe));
    busReq      = cpuReq && !hitOk;
    granted     = busReq && busGnt;
    dirtyVictim = (cpuState == LINE_M) && !cpuTagHit;

    // The command is chosen from the state seen in the granted cycle, so a
    // pending upgrade that lost its copy turns into a read-for-ownership.
    cmd = BUS_IDLE;
    if (granted) begin
      if (dirtyVictim)  cmd = BUS_WB;
      else if (hitS)    cmd = BUS_UPG;
      else if (cpuWe)   cmd = BUS_RDX;
      else              cmd = BUS_RD;
    end
    busCmdOut  = cmd;
    busAddrOut = dirtyVictim ? {victimTag, cpuAddr[IDX_W-1:0]} : cpuAddr;
    cpuReady   = hitOk;

    // Snoop side: only foreign traffic, i.e. never in our own granted cycle.
    snActive = !granted && snpTagHit && (snpState != LINE_I) &&
               (inCmd == BUS_RD || inCmd == BUS_RDX || inCmd == BUS_UPG);
    sameIdx  = (cpuAddr[IDX_W-1:0] == busAddrIn[IDX_W-1:0]);
    snoopFlush = snActive && (snpState == LINE_M) &&
                 (inCmd == BUS_RD || inCmd == BUS_RDX);
    // A write hit in this cycle is ordered before the foreign access.
    snoopData = (hitOk && cpuWe && sameIdx) ? cpuWdata : snpData;

    st.fillEn    = (cmd == BUS_RD) || (cmd == BUS_RDX);
    st.fillMod   = (cmd == BUS_RDX);
    st.upgEn     = (cmd == BUS_UPG);
    st.wbEn      = (cmd == BUS_WB);
    st.wrEn      = hitOk && cpuWe;
    st.snoopEn   = snActive;
    st.snoopNext = (inCmd == BUS_RD) ? LINE_S : LINE_I;
  end

  // R8
  cmd_only_granted_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busCmdOut != BUS_IDLE) |-> (busReq && busGnt));

  // R8
  req_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busGnt) |=> (busReq || !cpuReq));

  // R7
  wb_then_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busCmdOut == BUS_WB) |=> (busReq || !cpuReq));

  // R3
  fill_completes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busGnt && busCmdOut != BUS_WB) |=>
      (cpuReady || !cpuReq || cpuAddr != $past(cpuAddr) || cpuWe != $past(cpuWe)));

endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuReady,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              busReq,
  input  logic              busGnt,
  output logic [2:0]        busCmdOut,
  output logic [ADDR_W-1:0] busAddrOut,
  output logic [DATA_W-1:0] busDataOut,
  input  logic [2:0]        busCmdIn,
  input  logic [ADDR_W-1:0] busAddrIn,
  input  logic [DATA_W-1:0] busDataIn,
  output logic              snoopFlush,
  output logic [DATA_W-1:0] snoopData
);
  localparam int TAG_W = ADDR_W - IDX_W;

  lineStrobe_t       st;
  lineState_e        cpuState, snpState;
  logic              cpuTagHit, snpTagHit;
  logic [DATA_W-1:0] cpuData, snpData;
  logic [TAG_W-1:0]  victimTag;

  msi_snoop_ctl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) uCtl (
    .clk(clk), .rstN(rstN),
    .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuReady(cpuReady), .busReq(busReq), .busGnt(busGnt),
    .busCmdOut(busCmdOut), .busAddrOut(busAddrOut),
    .busCmdIn(busCmdIn), .busAddrIn(busAddrIn),
    .snoopFlush(snoopFlush), .snoopData(snoopData),
    .cpuState(cpuState), .cpuTagHit(cpuTagHit), .cpuData(cpuData),
    .victimTag(victimTag), .snpState(snpState), .snpTagHit(snpTagHit),
    .snpData(snpData), .st(st)
  );

  msi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) uStore (
    .clk(clk), .rstN(rstN), .st(st),
    .cpuIdx(cpuAddr[IDX_W-1:0]), .cpuTag(cpuAddr[ADDR_W-1:IDX_W]),
    .cpuWdata(cpuWdata), .fillData(busDataIn),
    .snpIdx(busAddrIn[IDX_W-1:0]), .snpTag(busAddrIn[ADDR_W-1:IDX_W]),
    .cpuState(cpuState), .cpuTagHit(cpuTagHit), .cpuData(cpuData),
    .victimTag(victimTag), .snpState(snpState), .snpTagHit(snpTagHit),
    .snpData(snpData)
  );

  assign cpuRdata   = cpuData;
  assign busDataOut = cpuData;

endmodule

// File: tb/tb_msi_snoop_ctrl.sv
module tb_msi_snoop_ctrl;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int MEMN = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;  // 8 ns period

  logic          req [2];
  logic          we  [2];
  logic [AW-1:0] addr[2];
  logic [DW-1:0] wd  [2];
  logic          ready[2];
  logic [DW-1:0] rdata[2];
  logic          bReq [2];
  logic          gnt  [2];
  logic [2:0]    bCmd [2];
  logic [AW-1:0] bAddr[2];
  logic [DW-1:0] bData[2];
  logic          flush[2];
  logic [DW-1:0] sData[2];

  logic [2:0]    busCmd;
  logic [AW-1:0] busAddr;
  logic [DW-1:0] busWb, busData;
  logic          lastW;
  logic [DW-1:0] mem   [MEMN];
  logic [DW-1:0] refMem[MEMN];

  int nChecks = 0;
  int nFail = 0;

  function automatic logic [DW-1:0] initVal(int a);
    return DW'(16'h1000 + a * 7);
  endfunction

  for (genvar g = 0; g < 2; g++) begin : cache
    msi_snoop_ctrl #(.ADDR_W(AW), .IDX_W(2), .DATA_W(DW)) dut (
      .clk(clk), .rstN(rstN),
      .cpuReq(req[g]), .cpuWe(we[g]), .cpuAddr(addr[g]), .cpuWdata(wd[g]),
      .cpuReady(ready[g]), .cpuRdata(rdata[g]),
      .busReq(bReq[g]), .busGnt(gnt[g]),
      .busCmdOut(bCmd[g]), .busAddrOut(bAddr[g]), .busDataOut(bData[g]),
      .busCmdIn(busCmd), .busAddrIn(busAddr), .busDataIn(busData),
      .snoopFlush(flush[g]), .snoopData(sData[g])
    );
  end

  // Round-robin arbiter and bus wiring.
  always_comb begin
    gnt[0]  = bReq[0] && (!bReq[1] || lastW);
    gnt[1]  = bReq[1] && !gnt[0];
    busCmd  = bCmd[0] | bCmd[1];
    busAddr = gnt[0] ? bAddr[0] : bAddr[1];
    busWb   = gnt[0] ? bData[0] : bData[1];
    busData = flush[0] ? sData[0] : (flush[1] ? sData[1] : mem[busAddr]);
  end

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEMN; i++) mem[i] <= initVal(i);
      lastW <= 1'b0;
    end else begin
      if (busCmd == 3'd4) mem[busAddr] <= busWb;
      if (flush[0]) mem[busAddr] <= sData[0];
      if (flush[1]) mem[busAddr] <= sData[1];
      if (gnt[0]) lastW <= 1'b0;
      else if (gnt[1]) lastW <= 1'b1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference model, compared on every clock away from the edge.
  always @(negedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEMN; i++) refMem[i] = initVal(i);
    end else begin
      for (int c = 0; c < 2; c++)
        if (req[c] && ready[c] && we[c]) refMem[addr[c]] = wd[c];
      for (int c = 0; c < 2; c++)
        if (req[c] && ready[c] && !we[c])
          check(rdata[c] == refMem[addr[c]], "R13 read value", rdata[c], refMem[addr[c]]);
      if (busCmd == 3'd1 || busCmd == 3'd2)
        check(busData == refMem[busAddr], "R13 fill value", busData, refMem[busAddr]);
      if (busCmd == 3'd4)
        check(busWb == refMem[busAddr], "R7 write-back data", busWb, refMem[busAddr]);
      check(!(flush[0] && flush[1]), "R12 single supplier", {flush[0], flush[1]}, 0);
      check(!(gnt[0] && gnt[1]), "R8 one owner", {gnt[0], gnt[1]}, 0);
    end
  end

  // Per-call logs of bus activity.
  int          lat[2];
  int          nLog, nFl;
  int          logCpu[8];
  logic [2:0]  logCmd[8];
  logic [AW-1:0] logAddr[8];
  logic [DW-1:0] logData[8];
  int          flCpu[8];
  logic [DW-1:0] flData[8];
  logic        firstReq0, firstReq1;
  int          firstCmds;

  task automatic setAcc(input int c, input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    we[c] = w; addr[c] = a; wd[c] = d;
  endtask

  task automatic go(input bit u0, input bit u1);
    bit p0, p1;
    int cyc;
    @(posedge clk); #1;
    req[0] = u0; req[1] = u1;
    p0 = u0; p1 = u1; cyc = 0;
    nLog = 0; nFl = 0; lat[0] = -1; lat[1] = -1;
    while (p0 || p1) begin
      @(negedge clk);
      if (cyc == 0) begin
        firstReq0 = bReq[0]; firstReq1 = bReq[1];
        firstCmds = int'(bCmd[0] != 0) + int'(bCmd[1] != 0);
      end
      if (busCmd != 0 && nLog < 8) begin
        logCpu[nLog] = gnt[0] ? 0 : 1; logCmd[nLog] = busCmd;
        logAddr[nLog] = busAddr; logData[nLog] = busWb; nLog++;
      end
      for (int c = 0; c < 2; c++)
        if (flush[c] && nFl < 8) begin flCpu[nFl] = c; flData[nFl] = sData[c]; nFl++; end
      if (p0 && ready[0]) begin lat[0] = cyc; p0 = 0; end
      if (p1 && ready[1]) begin lat[1] = cyc; p1 = 0; end
      @(posedge clk); #1;
      if (!p0) req[0] = 0;
      if (!p1) req[1] = 0;
      cyc++;
      if (cyc > 60) begin
        check(0, "R8 access hung", cyc, 60);
        p0 = 0; p1 = 0; req[0] = 0; req[1] = 0;
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    nFail++; nChecks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    logic [DW-1:0] valA, valB;
    int win;
    for (int c = 0; c < 2; c++) begin req[c] = 0; we[c] = 0; addr[c] = 0; wd[c] = 0; end
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    check(!bReq[0] && !bReq[1], "R1 no request after reset", {bReq[0], bReq[1]}, 0);
    check(busCmd == 0 && !ready[0] && !ready[1], "R1 idle bus and ready", busCmd, 0);

    // R1/R3: first read misses, fills Shared
    setAcc(0, 0, 8'h10, 0); go(1, 0);
    check(lat[0] == 1, "R3 read miss latency", lat[0], 1);
    check(nLog == 1 && logCmd[0] == 3'd1, "R1 R3 read miss issues read", logCmd[0], 1);

    // R2: read hit
    go(1, 0);
    check(lat[0] == 0 && nLog == 0, "R2 read hit no bus", lat[0], 0);

    // R5: write to Shared -> upgrade
    setAcc(0, 1, 8'h10, 16'hA001); go(1, 0);
    check(lat[0] == 1 && nLog == 1 && logCmd[0] == 3'd3, "R5 upgrade on shared write", logCmd[0], 3);

    // R4: write to Modified, no bus
    setAcc(0, 1, 8'h10, 16'hA002); go(1, 0);
    check(lat[0] == 0 && nLog == 0, "R4 modified write no bus", nLog, 0);

    // R9: foreign read of Modified line -> flush, local to Shared
    setAcc(1, 0, 8'h10, 0); go(0, 1);
    check(lat[1] == 1 && nFl == 1 && flCpu[0] == 0, "R9 flush on foreign read", nFl, 1);
    check(flData[0] == 16'hA002, "R9 flush data", flData[0], 16'hA002);
    setAcc(0, 1, 8'h10, 16'hA003); go(1, 0);
    check(lat[0] == 1 && logCmd[0] == 3'd3, "R9 demoted to shared needs upgrade", logCmd[0], 3);

    // R10: upgrade invalidated the peer, which must refetch
    setAcc(1, 0, 8'h10, 0); go(0, 1);
    check(lat[1] == 1 && logCmd[0] == 3'd1 && nFl == 1, "R10 peer invalidated by upgrade", logCmd[0], 1);

    // R6: write miss (clean victim in slot) -> read-for-ownership
    setAcc(1, 1, 8'h20, 16'hB001); go(0, 1);
    check(lat[1] == 1 && nLog == 1 && logCmd[0] == 3'd2, "R6 write miss rdx", logCmd[0], 2);
    setAcc(0, 1, 8'h20, 16'hB002); go(1, 0);
    check(lat[0] == 1 && logCmd[0] == 3'd2 && nFl == 1 && flCpu[0] == 1, "R10 rdx takes modified line", nFl, 1);
    check(flData[0] == 16'hB001, "R10 flush data on rdx", flData[0], 16'hB001);
    setAcc(1, 0, 8'h20, 0); go(0, 1);
    check(lat[1] == 1 && logCmd[0] == 3'd1, "R10 invalid after rdx", lat[1], 1);

    // R7: dirty victim written back before the fetch
    setAcc(0, 1, 8'h20, 16'hC001); go(1, 0);
    setAcc(0, 0, 8'h24, 0); go(1, 0);
    check(lat[0] == 2 && nLog == 2, "R7 victim then fetch latency", lat[0], 2);
    check(logCmd[0] == 3'd4 && logAddr[0] == 8'h20 && logData[0] == 16'hC001, "R7 write-back fields", logData[0], 16'hC001);
    check(logCmd[1] == 3'd1 && logAddr[1] == 8'h24, "R7 fetch after write-back", logAddr[1], 8'h24);
    setAcc(1, 0, 8'h20, 0); go(0, 1);

    // R12/R11/R8: competing writes to a shared line
    setAcc(0, 0, 8'h30, 0); go(1, 0);
    setAcc(1, 0, 8'h30, 0); go(0, 1);
    valA = 16'hD00A; valB = 16'hD00B;
    setAcc(0, 1, 8'h30, valA); setAcc(1, 1, 8'h30, valB); go(1, 1);
    check(firstReq0 && firstReq1 && firstCmds == 1, "R8 both request, one driven", firstCmds, 1);
    check((lat[0] == 1 && lat[1] == 2) || (lat[0] == 2 && lat[1] == 1), "R12 race latencies", lat[0] * 16 + lat[1], 18);
    win = (lat[0] == 1) ? 0 : 1;
    check(nLog == 2 && logCmd[0] == 3'd3 && logCpu[0] == win, "R12 winner upgrades", logCmd[0], 3);
    check(logCmd[1] == 3'd2 && logCpu[1] == 1 - win, "R12 loser refetches with rdx", logCmd[1], 2);
    check(nFl == 1 && flData[0] == (win == 0 ? valA : valB), "R11 same-cycle write forwarded to flush", flData[0], win == 0 ? valA : valB);
    setAcc(0, 0, 8'h30, 0); setAcc(1, 0, 8'h30, 0); go(1, 1);
    check(rdata[0] == rdata[1], "R12 both read final value", rdata[0], rdata[1]);

    // R13: mixed traffic, judged by the reference model each clock
    for (int i = 0; i < 400; i++) begin
      for (int c = 0; c < 2; c++) begin
        logic [AW-1:0] a;
        case ($urandom % 5)
          0: a = 8'h40; 1: a = 8'h44; 2: a = 8'h48; 3: a = 8'h41; default: a = 8'h45;
        endcase
        setAcc(c, 1'($urandom % 2), a, DW'($urandom));
      end
      go(1'($urandom % 4 != 0), 1'($urandom % 4 != 0));
    end

    repeat (2) @(posedge clk);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule